// File: doc/BRIEF.md
# Programmable Three-Digit Combination Lock

This block is a synchronous controller for a keypad lock. The user enters a short sequence of decimal digits, one per strobe, and then pulses an unlock request. The lock opens only if exactly the stored digits were entered in the right order. While the lock is open, any key press locks it again.

While open, a single program pulse puts the lock into program mode. The user types a new code and pulses unlock. The open output then rises to acknowledge the first entry. The user types the same code again and pulses unlock once more. If both entries agree, the new code is written into the internal code register. If they differ, the old code stays. In either case the lock ends up closed.

Keypad scanning and debouncing happen upstream, so every digit arrives clean and lasts one cycle.

Top module: `combo_lock_ctrl`

## Requirements
- R1: A synchronous reset closes the lock and leaves program mode. It also loads the default code, which is first digit 1, then 2, then 3.
- R2: In the locked state, the lock opens after three digits that match the stored code in order, followed by an unlock pulse. `lock_open` goes high in the cycle after the clock edge that samples the pulse.
- R3: A wrong digit, a wrong order or too few digits leaves the lock closed when unlock is pulsed. Every unlock pulse restarts the entry from the first digit.
- R4: A fourth digit before the unlock pulse makes the whole entry fail.
- R5: While the lock is open, any key strobe closes it. That digit is discarded and does not count toward the next entry.
- R6: A program pulse while locked has no effect. After it, a correct entry opens the lock into the plain open state, where a key press closes it.
- R7: A single program pulse while open latches program mode, and `lock_open` drops. Three digits and an unlock pulse then raise `lock_open` as the acknowledgement.
- R8: If the second entry equals the first, an unlock pulse writes the new code and closes the lock. After that, only the new code opens it.
- R9: If the second entry differs from the first, an unlock pulse closes the lock and the old code is kept.
- R10: In program mode, a first entry that is incomplete or contains a digit above 9 makes the unlock pulse leave program mode with the lock closed. The old code is kept.
- R11: A digit value above 9 never matches and never reaches the stored code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_vld | input | 1 | One-cycle strobe: `key_digit` is valid |
| key_digit | input | 4 | BCD digit from the keypad |
| unlock_req | input | 1 | One-cycle unlock / confirm pulse |
| prog_req | input | 1 | One-cycle request to enter program mode |
| lock_open | output | 1 | High while the lock is open or acknowledging a new code |

## Verification
Every result of this block is registered state. A digit strobe, an unlock pulse or a program pulse sampled at one rising edge shows on `lock_open` right after that edge. No other register sits between the inputs and the output. The bench changes each input on a falling edge and holds it for exactly one rising edge. It then reads `lock_open` on the following falling edge, which is where that result is due. Code changes are observed only through later unlock attempts at the ports.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_OPEN   = 2'd1,
    ST_PROG1  = 2'd2,
    ST_PROG2  = 2'd3
  } lock_st_e;

  function automatic logic is_bcd(input logic [DIGIT_W-1:0] d);
    return d <= 4'd9;
  endfunction
endpackage

// File: rtl/combo_entry.sv
module combo_entry
  import combo_lock_pkg::*;
#(
  parameter int DIGITS = 3,
  localparam int CW   = DIGITS * DIGIT_W,
  localparam int CNTW = $clog2(DIGITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                key_vld,
  input  logic [DIGIT_W-1:0]  key_digit,
  output logic [CW-1:0]       entry_code,
  output logic                full_clean
);
  logic [CNTW-1:0] cnt;
  logic            bad;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt        <= '0;
      bad        <= 1'b0;
      entry_code <= '0;
    end else if (key_vld) begin
      if (cnt == CNTW'(DIGITS)) begin
        bad <= 1'b1;
      end else begin
        entry_code[int'(cnt)*DIGIT_W +: DIGIT_W] <= key_digit;
        cnt <= cnt + 1'b1;
        if (!is_bcd(key_digit)) bad <= 1'b1;
      end
    end
  end

  assign full_clean = (cnt == CNTW'(DIGITS)) && !bad;
endmodule

// File: rtl/combo_code_store.sv
module combo_code_store
  import combo_lock_pkg::*;
#(
  parameter int DIGITS = 3,
  localparam int CW = DIGITS * DIGIT_W,
  parameter logic [CW-1:0] DEF_CODE = 12'h321
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend_we,
  input  logic          commit,
  input  logic [CW-1:0] entry_code,
  output logic [CW-1:0] stored_code,
  output logic [CW-1:0] pending_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stored_code  <= DEF_CODE;
      pending_code <= '0;
    end else begin
      if (pend_we) pending_code <= entry_code;
      if (commit)  stored_code  <= pending_code;
    end
  end
endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm
  import combo_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     key_vld,
  input  logic     unlock_req,
  input  logic     prog_req,
  input  logic     full_clean,
  input  logic     match_stored,
  input  logic     match_pending,
  output lock_st_e state,
  output logic     pend_we,
  output logic     commit
);
  lock_st_e nxt;

  always_comb begin
    nxt     = state;
    pend_we = 1'b0;
    commit  = 1'b0;
    case (state)
      ST_LOCKED: if (unlock_req && full_clean && match_stored) nxt = ST_OPEN;
      ST_OPEN: begin
        if (key_vld)       nxt = ST_LOCKED;
        else if (prog_req) nxt = ST_PROG1;
      end
      ST_PROG1: if (unlock_req) begin
        if (full_clean) begin
          nxt     = ST_PROG2;
          pend_we = 1'b1;
        end else begin
          nxt = ST_LOCKED;
        end
      end
      ST_PROG2: if (unlock_req) begin
        nxt    = ST_LOCKED;
        commit = full_clean && match_pending;
      end
      default: nxt = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LOCKED;
    else     state <= nxt;
  end
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
  import combo_lock_pkg::*;
#(
  parameter int DIGITS = 3,
  localparam int CW = DIGITS * DIGIT_W,
  parameter logic [CW-1:0] DEF_CODE = 12'h321
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_vld,
  input  logic [DIGIT_W-1:0] key_digit,
  input  logic               unlock_req,
  input  logic               prog_req,
  output logic               lock_open
);
  lock_st_e      state;
  logic [CW-1:0] entry_code, stored_code, pending_code;
  logic          full_clean, match_stored, match_pending;
  logic          pend_we, commit, entry_clr;
  logic          in_open, in_locked, in_prog1, in_prog2;

  assign in_open   = (state == ST_OPEN);
  assign in_locked = (state == ST_LOCKED);
  assign in_prog1  = (state == ST_PROG1);
  assign in_prog2  = (state == ST_PROG2);

  assign entry_clr     = unlock_req || in_open;
  assign match_stored  = (entry_code == stored_code);
  assign match_pending = (entry_code == pending_code);

  combo_entry #(.DIGITS(DIGITS)) u_entry (
    .clk(clk), .rst(rst), .clr(entry_clr), .key_vld(key_vld),
    .key_digit(key_digit), .entry_code(entry_code), .full_clean(full_clean)
  );

  combo_code_store #(.DIGITS(DIGITS), .DEF_CODE(DEF_CODE)) u_store (
    .clk(clk), .rst(rst), .pend_we(pend_we), .commit(commit),
    .entry_code(entry_code), .stored_code(stored_code), .pending_code(pending_code)
  );

  combo_lock_fsm u_fsm (
    .clk(clk), .rst(rst), .key_vld(key_vld), .unlock_req(unlock_req),
    .prog_req(prog_req), .full_clean(full_clean), .match_stored(match_stored),
    .match_pending(match_pending), .state(state), .pend_we(pend_we), .commit(commit)
  );

  assign lock_open = in_open || in_prog2;
endmodule

// File: rtl/combo_lock_checker.sv
module combo_lock_checker
  import combo_lock_pkg::*;
#(
  parameter int DIGITS = 3,
  localparam int CW = DIGITS * DIGIT_W
) (
  input logic          clk,
  input logic          rst,
  input logic          key_vld,
  input logic          unlock_req,
  input logic          prog_req,
  input logic          lock_open,
  input logic          in_open,
  input logic          in_locked,
  input logic          in_prog1,
  input logic          commit,
  input logic [CW-1:0] stored_code
);
  logic code_bcd;
  always_comb begin
    code_bcd = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (!is_bcd(stored_code[i*DIGIT_W +: DIGIT_W])) code_bcd = 1'b0;
  end

  AST_RESET_CLOSED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lock_open); // R1
  AST_OPEN_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_open) |-> $past(unlock_req)); // R2
  AST_KEY_RELOCKS: assert property (@(posedge clk) disable iff (rst)
    in_open && key_vld |=> !lock_open); // R5
  AST_PROG_IGNORED_LOCKED: assert property (@(posedge clk) disable iff (rst)
    in_locked && prog_req |=> !in_prog1); // R6
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(stored_code)); // R8
  AST_CODE_BCD: assert property (@(posedge clk) disable iff (rst)
    code_bcd); // R11
endmodule

bind combo_lock_ctrl combo_lock_checker #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst(rst), .key_vld(key_vld), .unlock_req(unlock_req),
  .prog_req(prog_req), .lock_open(lock_open), .in_open(in_open),
  .in_locked(in_locked), .in_prog1(in_prog1), .commit(commit),
  .stored_code(stored_code)
);

// File: tb/sim_combo_lock_ctrl.sv
`timescale 1ns/1ps
module sim_combo_lock_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_vld = 1'b0;
  logic [3:0] key_digit = 4'd0;
  logic unlock_req = 1'b0;
  logic prog_req = 1'b0;
  logic lock_open;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  combo_lock_ctrl u0 (
    .clk(clk), .rst(rst), .key_vld(key_vld), .key_digit(key_digit),
    .unlock_req(unlock_req), .prog_req(prog_req), .lock_open(lock_open)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (lock_open !== exp) begin
      n_err++;
      $display("FAIL %s lock_open actual=%b expected=%b", req, lock_open, exp);
    end
  endtask

  // each helper starts and ends on a falling edge
  task automatic press(input logic [3:0] d);
    key_digit = d; key_vld = 1'b1;
    @(negedge clk);
    key_vld = 1'b0;
  endtask

  task automatic unlock();
    unlock_req = 1'b1;
    @(negedge clk);
    unlock_req = 1'b0;
  endtask

  task automatic prog();
    prog_req = 1'b1;
    @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic enter3(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    press(a); press(b); press(c);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_default();
    do_reset();
    check(1'b0, "R1 closed after reset");
    enter3(1, 2, 3); unlock();
    check(1'b1, "R1/R2 default code 1-2-3 opens");
    press(0);
    check(1'b0, "R5 key relocks");
  endtask

  task automatic t_relock_discard();
    enter3(1, 2, 3); unlock();
    check(1'b1, "R2 open again");
    press(1);
    check(1'b0, "R5 key closes open lock");
    press(2); press(3); unlock();
    check(1'b0, "R5 relocking digit not counted");
    enter3(1, 2, 3); unlock();
    check(1'b1, "R3 entry restarts after unlock");
    press(9);
  endtask

  task automatic t_wrong();
    enter3(1, 3, 2); unlock();
    check(1'b0, "R3 wrong order stays closed");
    press(1); press(2); unlock();
    check(1'b0, "R3 two digits stays closed");
    enter3(4, 2, 3); unlock();
    check(1'b0, "R3 wrong first digit stays closed");
    enter3(1, 2, 3); press(3); unlock();
    check(1'b0, "R4 four digits fail");
    press(1); press(2); press(4'd11); unlock();
    check(1'b0, "R11 digit above 9 mismatches");
  endtask

  task automatic t_prog_locked();
    prog();
    enter3(1, 2, 3); unlock();
    check(1'b1, "R6 opens after ignored program pulse");
    press(5);
    check(1'b0, "R6 plain open state, key relocks");
  endtask

  task automatic t_prog_ok();
    enter3(1, 2, 3); unlock();
    prog();
    check(1'b0, "R7 program mode drops open");
    enter3(4, 5, 6); unlock();
    check(1'b1, "R7 first entry acknowledged");
    enter3(4, 5, 6); unlock();
    check(1'b0, "R8 closed after commit");
    enter3(1, 2, 3); unlock();
    check(1'b0, "R8 old code rejected");
    enter3(4, 5, 6); unlock();
    check(1'b1, "R8 new code opens");
  endtask

  task automatic t_prog_mismatch();
    prog();
    enter3(7, 8, 9); unlock();
    check(1'b1, "R7 acknowledge 7-8-9");
    enter3(7, 8, 0); unlock();
    check(1'b0, "R9 mismatch closes");
    enter3(7, 8, 9); unlock();
    check(1'b0, "R9 rejected code not stored");
    enter3(4, 5, 6); unlock();
    check(1'b1, "R9 old code kept");
  endtask

  task automatic t_prog_abort();
    prog();
    press(7); press(4'd12); press(9); unlock();
    check(1'b0, "R10 non-BCD first entry aborts");
    enter3(4, 5, 6); unlock();
    check(1'b1, "R10 old code kept after abort");
    prog();
    press(7); press(8); unlock();
    check(1'b0, "R10 short first entry aborts");
    enter3(4, 5, 6); unlock();
    check(1'b1, "R10 old code kept after short entry");
    press(0);
  endtask

  task automatic t_reset_restore();
    do_reset();
    enter3(4, 5, 6); unlock();
    check(1'b0, "R1 programmed code cleared by reset");
    enter3(1, 2, 3); unlock();
    check(1'b1, "R1 default restored");
  endtask

  initial begin
    @(negedge clk);
    t_reset_default();
    t_relock_discard();
    t_wrong();
    t_prog_locked();
    t_prog_ok();
    t_prog_mismatch();
    t_prog_abort();
    t_reset_restore();
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule